// File: doc/BRIEF.md
# Choke-Packet Congestion Controller

This block pairs a congested switch's reaction with the throttle it drives at a traffic source. On the switch side it watches the fill level of a buffer and raises a warning flag once the level climbs past a high mark. It keeps the flag up until the level drops under a lower mark. Every packet that arrives while the flag is up produces one choke notice the next cycle. The notice is addressed to that packet's source and names the packet's destination.

On the source side, each destination has its own 8-bit injection rate and a token accumulator. Incoming choke notices cut only the named destination's rate. If a destination receives no choke for a programmable number of cycles, its rate climbs back one step at a time. A send to a destination is allowed only when that destination's accumulator is full. No bandwidth is reserved anywhere: under contention, traffic is simply held at the point of entry. Carrying choke notices across a real network is left to the surrounding fabric, so the choke input ports here take them directly.

Top module: `choke_throttle`

## Requirements
- R1: The warning flag `warn` reads 1 in the cycle after one in which `occ_level` is at or above HI_THR (default 48).
- R2: The warning flag clears in the cycle after one in which `occ_level` is below LO_THR (default 32). For levels in [LO_THR, HI_THR) it keeps its previous value.
- R3: A clock edge that sees `pkt_valid` with `warn` at 1 produces `choke_valid` = 1 for the next cycle, with `choke_to` equal to `pkt_src` and `choke_dst` equal to `pkt_dst`. Any other edge leaves `choke_valid` at 0.
- R4: During and right after reset, `warn` and `choke_valid` are 0, every rate is 255 and `tx_ready` is all zeros.
- R5: A choke naming destination d sets rate d to r − max(r>>2, 1), with a floor of 1. The rates of other destinations do not change. Rate d sits at bits [8d+7:8d] of `rate_flat`.
- R6: Two or more choke inputs naming the same destination in one cycle apply a single reduction to it.
- R7: After `recov_cycles` consecutive edges with no choke for a destination, its rate rises by 1, and this repeats every further `recov_cycles` edges up to a maximum of 255. A choke restarts the count.
- R8: Each edge adds the rate to the destination's accumulator, capped at 256. Bit d of `tx_ready` is 1 when accumulator d equals 256. `send_ok` is `send_valid` AND bit `send_dst` of `tx_ready`. An accepted send subtracts 256 before the rate is added.
- R9: A send request toward a destination whose `tx_ready` bit is 0 gives `send_ok` = 0 and leaves that accumulator's refill timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_level | input | OCC_W | Current switch buffer fill level |
| pkt_valid | input | 1 | A packet arrives at the switch this cycle |
| pkt_src | input | ID_W | Source node of the arriving packet |
| pkt_dst | input | ID_W | Destination of the arriving packet |
| warn | output | 1 | Switch warning state |
| choke_valid | output | 1 | Choke notice is being emitted |
| choke_to | output | ID_W | Node the choke notice goes back to |
| choke_dst | output | ID_W | Destination to be throttled |
| choke_in_valid | input | NCH | Valid bit for each incoming choke port |
| choke_in_dst | input | NCH*ID_W | Destination named by each incoming choke, port p at bits [p*ID_W +: ID_W] |
| recov_cycles | input | CNT_W | Choke-free edges per recovery step |
| send_valid | input | 1 | Source asks to inject a packet |
| send_dst | input | ID_W | Destination of the requested injection |
| send_ok | output | 1 | The requested injection is granted this cycle |
| tx_ready | output | NDST | Per-destination token-full flags |
| rate_flat | output | NDST*8 | All per-destination rates, packed |

## Verification
A stuck or wrongly held warning flag appears on `warn` one edge after the fill level crosses a mark. The very next packet then shows it as a missing or extra choke notice. A reduction applied to the wrong lane, or applied twice, shows up in `rate_flat` on the edge that follows the choke. A wrong recovery counter shows up exactly `recov_cycles` edges later as a missing or early +1. An accumulator fault moves the return of a `tx_ready` bit. This is easiest to see at rate 1, where the refill takes 256 edges and an off-by-one is exact.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int RATE_W = 8;
    localparam int ACC_W  = RATE_W + 1;

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [ACC_W-1:0]  acc_t;

    localparam rate_t RATE_MAX = '1;
    localparam acc_t  ACC_FULL = acc_t'(1) << RATE_W;

    typedef enum logic {
        ST_CALM = 1'b0,
        ST_WARN = 1'b1
    } warn_e;

    // Multiplicative cut by a quarter, always at least one step, never below 1.
    function automatic rate_t cut_rate(rate_t r);
        rate_t step;
        step = ((r >> 2) == '0) ? rate_t'(1) : (r >> 2);
        return (r > step) ? (r - step) : rate_t'(1);
    endfunction

    // Token refill: optional spend of one full bucket, then add rate, cap at full.
    function automatic acc_t refill(acc_t a, rate_t r, logic take);
        logic [ACC_W:0] s;
        acc_t base;
        base = take ? (a - ACC_FULL) : a;
        s = {1'b0, base} + (ACC_W+1)'(r);
        return (s >= {1'b0, ACC_FULL}) ? ACC_FULL : s[ACC_W-1:0];
    endfunction

endpackage

// File: rtl/ct_warn_unit.sv
module ct_warn_unit
    import ct_pkg::*;
#(
    parameter int OCC_W  = 6,
    parameter int HI_THR = 48,
    parameter int LO_THR = 32,
    parameter int ID_W   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OCC_W-1:0] occ_level,
    input  logic            pkt_valid,
    input  logic [ID_W-1:0] pkt_src,
    input  logic [ID_W-1:0] pkt_dst,
    output logic            warn,
    output logic            choke_valid,
    output logic [ID_W-1:0] choke_to,
    output logic [ID_W-1:0] choke_dst
);

    localparam logic [OCC_W-1:0] HI_LVL = OCC_W'(HI_THR);
    localparam logic [OCC_W-1:0] LO_LVL = OCC_W'(LO_THR);

    warn_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (occ_level >= HI_LVL)     state_d = ST_WARN;
        else if (occ_level < LO_LVL) state_d = ST_CALM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_CALM;
            choke_valid <= 1'b0;
            choke_to    <= '0;
            choke_dst   <= '0;
        end else begin
            state_q     <= state_d;
            choke_valid <= pkt_valid && (state_q == ST_WARN);
            if (pkt_valid) begin
                choke_to  <= pkt_src;
                choke_dst <= pkt_dst;
            end
        end
    end

    assign warn = (state_q == ST_WARN);

endmodule

// File: rtl/ct_dest_lane.sv
module ct_dest_lane
    import ct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             choke,
    input  logic [CNT_W-1:0] recov_cycles,
    input  logic             take,
    output rate_t            rate,
    output logic             ready
);

    logic [CNT_W-1:0] quiet_q;
    logic [CNT_W:0]   quiet_inc;
    logic             expire;
    acc_t             acc_q;

    assign quiet_inc = {1'b0, quiet_q} + (CNT_W+1)'(1);
    assign expire    = quiet_inc >= {1'b0, recov_cycles};

    always_ff @(posedge clk) begin
        if (rst) begin
            rate    <= RATE_MAX;
            quiet_q <= '0;
        end else if (choke) begin
            rate    <= cut_rate(rate);
            quiet_q <= '0;
        end else if (expire) begin
            quiet_q <= '0;
            if (rate != RATE_MAX) rate <= rate + rate_t'(1);
        end else begin
            quiet_q <= quiet_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= refill(acc_q, rate, take);
    end

    assign ready = (acc_q == ACC_FULL);

endmodule

// File: rtl/choke_throttle.sv
module choke_throttle
    import ct_pkg::*;
#(
    parameter int NDST   = 4,
    parameter int NCH    = 2,
    parameter int OCC_W  = 6,
    parameter int HI_THR = 48,
    parameter int LO_THR = 32,
    parameter int CNT_W  = 16,
    localparam int ID_W  = (NDST > 1) ? $clog2(NDST) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [OCC_W-1:0]       occ_level,
    input  logic                   pkt_valid,
    input  logic [ID_W-1:0]        pkt_src,
    input  logic [ID_W-1:0]        pkt_dst,
    output logic                   warn,
    output logic                   choke_valid,
    output logic [ID_W-1:0]        choke_to,
    output logic [ID_W-1:0]        choke_dst,
    input  logic [NCH-1:0]         choke_in_valid,
    input  logic [NCH*ID_W-1:0]    choke_in_dst,
    input  logic [CNT_W-1:0]       recov_cycles,
    input  logic                   send_valid,
    input  logic [ID_W-1:0]        send_dst,
    output logic                   send_ok,
    output logic [NDST-1:0]        tx_ready,
    output logic [NDST*RATE_W-1:0] rate_flat
);

    logic [NDST-1:0] choke_hit;
    logic [NDST-1:0] take;

    ct_warn_unit #(
        .OCC_W(OCC_W), .HI_THR(HI_THR), .LO_THR(LO_THR), .ID_W(ID_W)
    ) u_warn (
        .clk(clk), .rst(rst), .occ_level(occ_level),
        .pkt_valid(pkt_valid), .pkt_src(pkt_src), .pkt_dst(pkt_dst),
        .warn(warn), .choke_valid(choke_valid),
        .choke_to(choke_to), .choke_dst(choke_dst)
    );

    // Merge all choke ports into one hit per destination: duplicates collapse.
    always_comb begin
        choke_hit = '0;
        for (int p = 0; p < NCH; p++) begin
            for (int d = 0; d < NDST; d++) begin
                if (choke_in_valid[p] && (choke_in_dst[p*ID_W +: ID_W] == ID_W'(d)))
                    choke_hit[d] = 1'b1;
            end
        end
    end

    generate
        for (genvar d = 0; d < NDST; d++) begin : g_lane
            assign take[d] = send_valid && (send_dst == ID_W'(d)) && tx_ready[d];

            ct_dest_lane #(.CNT_W(CNT_W)) u_lane (
                .clk(clk), .rst(rst),
                .choke(choke_hit[d]),
                .recov_cycles(recov_cycles),
                .take(take[d]),
                .rate(rate_flat[d*RATE_W +: RATE_W]),
                .ready(tx_ready[d])
            );
        end
    endgenerate

    assign send_ok = |take;

endmodule

// File: rtl/ct_checker.sv
module ct_checker
    import ct_pkg::*;
#(
    parameter int NDST   = 4,
    parameter int NCH    = 2,
    parameter int OCC_W  = 6,
    parameter int HI_THR = 48,
    parameter int LO_THR = 32,
    parameter int CNT_W  = 16,
    localparam int ID_W  = (NDST > 1) ? $clog2(NDST) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [OCC_W-1:0]       occ_level,
    input logic                   pkt_valid,
    input logic [ID_W-1:0]        pkt_src,
    input logic [ID_W-1:0]        pkt_dst,
    input logic                   warn,
    input logic                   choke_valid,
    input logic [ID_W-1:0]        choke_to,
    input logic [ID_W-1:0]        choke_dst,
    input logic [NCH-1:0]         choke_in_valid,
    input logic [NCH*ID_W-1:0]    choke_in_dst,
    input logic [CNT_W-1:0]       recov_cycles,
    input logic                   send_valid,
    input logic [ID_W-1:0]        send_dst,
    input logic                   send_ok,
    input logic [NDST-1:0]        tx_ready,
    input logic [NDST*RATE_W-1:0] rate_flat
);

    logic  hit0;
    rate_t rate0;

    assign rate0 = rate_flat[RATE_W-1:0];

    always_comb begin
        hit0 = 1'b0;
        for (int p = 0; p < NCH; p++)
            if (choke_in_valid[p] && choke_in_dst[p*ID_W +: ID_W] == '0) hit0 = 1'b1;
    end

    p_warn_set_r1: assert property (@(posedge clk) disable iff (rst)
        occ_level >= OCC_W'(HI_THR) |=> warn);

    p_warn_clr_r2: assert property (@(posedge clk) disable iff (rst)
        occ_level < OCC_W'(LO_THR) |=> !warn);

    p_warn_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (occ_level >= OCC_W'(LO_THR) && occ_level < OCC_W'(HI_THR)) |=> warn == $past(warn));

    p_choke_emit_r3: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && warn) |=> (choke_valid && choke_to == $past(pkt_src) && choke_dst == $past(pkt_dst)));

    p_choke_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid && warn) |=> !choke_valid);

    p_rate_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (rate0 < $past(rate0)) |-> $past(hit0));

    p_rate_step_r7: assert property (@(posedge clk) disable iff (rst)
        (rate0 > $past(rate0)) |-> (rate0 == $past(rate0) + rate_t'(1) && !$past(hit0)));

    p_send_gate_r8: assert property (@(posedge clk) disable iff (rst)
        send_ok |-> (send_valid && tx_ready[send_dst]));

    p_spend_r8: assert property (@(posedge clk) disable iff (rst)
        (send_ok && send_dst == '0 && rate0 != RATE_MAX) |=> !tx_ready[0]);

    always_comb begin
        if (!rst) p_rate_nonzero_r5: assert (rate0 != '0);
    end

endmodule

bind choke_throttle ct_checker #(
    .NDST(NDST), .NCH(NCH), .OCC_W(OCC_W),
    .HI_THR(HI_THR), .LO_THR(LO_THR), .CNT_W(CNT_W)
) u_ct_checker (.*);

// File: tb/tb_choke_throttle.sv
module tb_choke_throttle;
    import ct_pkg::*;

    localparam int PERIOD = 10;
    localparam int NDST = 4;
    localparam int NCH  = 2;
    localparam int ID_W = 2;

    logic clk = 1'b0;
    logic rst;
    logic [5:0] occ_level;
    logic pkt_valid;
    logic [ID_W-1:0] pkt_src, pkt_dst;
    logic warn, choke_valid;
    logic [ID_W-1:0] choke_to, choke_dst;
    logic [NCH-1:0] choke_in_valid;
    logic [NCH*ID_W-1:0] choke_in_dst;
    logic [15:0] recov_cycles;
    logic send_valid;
    logic [ID_W-1:0] send_dst;
    logic send_ok;
    logic [NDST-1:0] tx_ready;
    logic [NDST*8-1:0] rate_flat;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;
    int exp_rate [NDST];

    always #(PERIOD/2) clk = ~clk;

    choke_throttle dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_cut(int r);
        int step;
        step = (r / 4 == 0) ? 1 : r / 4;
        return (r > step) ? r - step : 1;
    endfunction

    function automatic int rate_of(int d);
        return int'(rate_flat[d*8 +: 8]);
    endfunction

    task automatic check_rates(string tag);
        for (int d = 0; d < NDST; d++) check(tag, rate_of(d), exp_rate[d]);
    endtask

    task automatic choke_once(logic [1:0] v, int d0, int d1);
        choke_in_valid = v;
        choke_in_dst   = {ID_W'(d1), ID_W'(d0)};
        tick();
        choke_in_valid = '0;
    endtask

    task automatic test_reset();
        check("R4 warn", int'(warn), 0);
        check("R4 choke_valid", int'(choke_valid), 0);
        check("R4 tx_ready", int'(tx_ready), 0);
        for (int d = 0; d < NDST; d++) exp_rate[d] = 255;
        check_rates("R4 rate");
    endtask

    task automatic test_token();
        tick();
        check("R8 not full after one edge", int'(tx_ready), 0);
        tick();
        check("R8 full after two edges", int'(tx_ready), 15);
        send_valid = 1'b1; send_dst = 2'd0;
        #1;
        check("R8 send_ok granted", int'(send_ok), 1);
        tick();
        send_valid = 1'b0;
        check("R8 spent bucket", int'(tx_ready), 14);
        tick();
        check("R8 bucket refilled", int'(tx_ready), 15);
    endtask

    task automatic test_warn();
        occ_level = 6'd47; tick();
        check("R1 below high mark", int'(warn), 0);
        occ_level = 6'd48; tick();
        check("R1 at high mark", int'(warn), 1);
        occ_level = 6'd32; tick();
        check("R2 held at low mark", int'(warn), 1);
        occ_level = 6'd31; tick();
        check("R2 cleared below low mark", int'(warn), 0);
        occ_level = 6'd40; tick();
        check("R2 held off in band", int'(warn), 0);
        occ_level = 6'd63; tick();
        check("R1 set again", int'(warn), 1);
    endtask

    task automatic test_choke_emit();
        pkt_valid = 1'b1; pkt_src = 2'd2; pkt_dst = 2'd3; tick();
        check("R3 choke valid", int'(choke_valid), 1);
        check("R3 choke_to", int'(choke_to), 2);
        check("R3 choke_dst", int'(choke_dst), 3);
        pkt_src = 2'd1; pkt_dst = 2'd0; tick();
        check("R3 second choke_to", int'(choke_to), 1);
        check("R3 second choke_dst", int'(choke_dst), 0);
        pkt_valid = 1'b0; tick();
        check("R3 no packet no choke", int'(choke_valid), 0);
        occ_level = 6'd0; tick();
        pkt_valid = 1'b1; tick();
        check("R3 calm switch no choke", int'(choke_valid), 0);
        pkt_valid = 1'b0;
    endtask

    task automatic test_cut();
        choke_once(2'b01, 1, 0);
        exp_rate[1] = model_cut(exp_rate[1]);
        check_rates("R5 single cut on dst1");
        choke_once(2'b11, 1, 1);
        exp_rate[1] = model_cut(exp_rate[1]);
        check_rates("R6 duplicate chokes one cut");
        choke_once(2'b11, 0, 3);
        exp_rate[0] = model_cut(exp_rate[0]);
        exp_rate[3] = model_cut(exp_rate[3]);
        check_rates("R5 two destinations cut");
    endtask

    task automatic test_floor();
        for (int i = 0; i < 25; i++) begin
            choke_once(2'b10, 0, 2);
            exp_rate[2] = model_cut(exp_rate[2]);
        end
        check("R5 floor at one", rate_of(2), 1);
        check_rates("R5 floor others untouched");
    endtask

    task automatic test_refill();
        check("R8 dst2 full before send", int'(tx_ready[2]), 1);
        send_valid = 1'b1; send_dst = 2'd2; tick();
        send_valid = 1'b0;
        check("R8 dst2 empty after send", int'(tx_ready[2]), 0);
        for (int i = 0; i < 254; i++) begin
            if (i == 100) begin
                send_valid = 1'b1; send_dst = 2'd2;
                #1;
                check("R9 send refused when not full", int'(send_ok), 0);
            end
            tick();
            send_valid = 1'b0;
        end
        check("R9 still not full after 255 edges", int'(tx_ready[2]), 0);
        tick();
        check("R8 full after 256 edges at rate 1", int'(tx_ready[2]), 1);
    endtask

    task automatic test_recover();
        recov_cycles = 16'd5;
        choke_once(2'b01, 1, 0);
        exp_rate[1] = model_cut(exp_rate[1]);
        repeat (4) tick();
        check("R7 no step before interval", rate_of(1), exp_rate[1]);
        tick();
        exp_rate[1]++;
        check("R7 first step", rate_of(1), exp_rate[1]);
        repeat (5) tick();
        exp_rate[1]++;
        check("R7 second step", rate_of(1), exp_rate[1]);
        repeat (3) tick();
        choke_once(2'b01, 1, 0);
        exp_rate[1] = model_cut(exp_rate[1]);
        repeat (4) tick();
        check("R7 choke restarts count", rate_of(1), exp_rate[1]);
        tick();
        exp_rate[1]++;
        check("R7 step after restart", rate_of(1), exp_rate[1]);
        recov_cycles = 16'd0;
        repeat (300) tick();
        for (int d = 0; d < NDST; d++) exp_rate[d] = 255;
        check_rates("R7 saturates at max");
    endtask

    initial begin
        rst = 1'b1;
        occ_level = '0; pkt_valid = 1'b0; pkt_src = '0; pkt_dst = '0;
        choke_in_valid = '0; choke_in_dst = '0;
        recov_cycles = 16'hFFFF;
        send_valid = 1'b0; send_dst = '0;
        repeat (3) tick();
        test_reset();
        rst = 1'b0;
        test_token();
        test_warn();
        test_choke_emit();
        test_cut();
        test_floor();
        test_refill();
        test_recover();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule